// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block runs one access at a time to an asynchronous parallel memory. It drives an active-low chip-select line for the addressed device, an address-valid strobe, a write strobe and a read (output-enable) strobe. Each strobe edge sits at a programmable number of clock cycles after the access begins. A host hands over a request through a valid/ready handshake and gives the write direction, a device index, an address and write data. The timing inputs are already expressed in clock cycles. When the access finishes, the block returns a one-cycle completion pulse, and for reads it also returns the word sampled at the programmed data-valid time.

Between accesses the block keeps the bus quiet for a programmable turnaround interval. It can add a further programmable gap that forces chip-select to stay high. One enable bit applies this gap when the next access goes to the same device, and a second enable bit applies it when the next access goes to a different device. Each strobe can be retimed half a clock later, and a single scale bit doubles every timing value. All timing inputs left at zero give a one-cycle access with no strobe asserted.

The controller has two states. `ST_IDLE` counts quiet cycles and accepts a request once the required gap has elapsed (transition *accept*). `ST_ACCESS` advances a cycle index from 0 and returns to `ST_IDLE` on the last cycle of the access (transition *finish*). Cycle index 0 is the first clock cycle after the edge that accepts a request.

Top module: `strobe_seq`

## Requirements
- R1: After reset, every `mem_cs_n` bit and `mem_adv_n`, `mem_we_n` and `mem_oe_n` are high, `done` is low, `rdata` is zero and `req_ready` is high. While `req_ready` has been high for two consecutive cycles, all strobes stay high.
- R2: Only the `mem_cs_n` bit whose index equals the accepted `req_cs` may go low. It is low in cycle t when `cs_on` ≤ t < off and t < L. Here off is `cs_off_wr` for writes and `cs_off_rd` for reads, and L is the access length from R7.
- R3: `mem_adv_n` is low when `adv_on` ≤ t < off and t < L. Here off is `adv_off_wr` for writes and `adv_off_rd` for reads.
- R4: `mem_we_n` is low when `we_on` ≤ t < `we_off` and t < L. `mem_oe_n` is low when `oe_on` ≤ t < `oe_off` and t < L. These windows apply to both reads and writes.
- R5: `half_dly` bit 0 (chip-select), bit 1 (ADV), bit 2 (WE) and bit 3 (OE) each move that strobe half a clock later. The first half of cycle t then shows the level of cycle t−1, and the second half shows the level of cycle t.
- R6: When `tm_x2` is high, every timing input is doubled before use, including the lengths, the data-valid time, the turnaround and the gap.
- R7: An access lasts L cycles, where L = max(1, `wr_len` or `rd_len`) according to direction. `done` is high for exactly the one cycle t = L and low otherwise.
- R8: A read captures `mem_rdata` at the end of cycle min(`acc_time`, L−1) and presents it on `rdata` while `done` is high. A write leaves `rdata` unchanged.
- R9: Counting the `done` cycle as 0, `req_ready` first rises N cycles later, where N = `turn_len` plus any gap from R10.
- R10: The gap `gap_len` is added to N when the new `req_cs` equals the previous one and `gap_same_en` is high, or when it differs and `gap_diff_en` is high.
- R11: `mem_addr` and `mem_wdata` carry the accepted request from cycle 0 through the `done` cycle and do not change until the next acceptance.
- R12: `req_ready` is low in every cycle of an access. The cycle after an acceptance never accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (strobes may also change on its falling edge) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_cs | input | CS_W | Device index to select |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last captured read word |
| cs_on | input | CNT_W | Chip-select assert cycle |
| cs_off_rd | input | CNT_W | Chip-select release cycle, reads |
| cs_off_wr | input | CNT_W | Chip-select release cycle, writes |
| adv_on | input | CNT_W | Address-valid assert cycle |
| adv_off_rd | input | CNT_W | Address-valid release cycle, reads |
| adv_off_wr | input | CNT_W | Address-valid release cycle, writes |
| we_on | input | CNT_W | Write strobe assert cycle |
| we_off | input | CNT_W | Write strobe release cycle |
| oe_on | input | CNT_W | Output enable assert cycle |
| oe_off | input | CNT_W | Output enable release cycle |
| acc_time | input | CNT_W | Read data-valid cycle |
| rd_len | input | CNT_W | Read access length |
| wr_len | input | CNT_W | Write access length |
| turn_len | input | CNT_W | Bus turnaround cycles |
| gap_len | input | CNT_W | Extra chip-select-high gap |
| gap_same_en | input | 1 | Apply gap for same device |
| gap_diff_en | input | 1 | Apply gap for different device |
| half_dly | input | 4 | Half-cycle retime per strobe (0 CS, 1 ADV, 2 WE, 3 OE) |
| tm_x2 | input | 1 | Double all timing values |
| mem_cs_n | output | NCS | Active-low chip-selects |
| mem_adv_n | output | 1 | Active-low address valid |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
A wrong cycle index shows up at once as a strobe edge in the wrong half-cycle. The bench checks every half of every cycle of every access, so such a fault is caught in the same cycle it first appears. A wrong idle count or a stale previous device index moves the first `req_ready` after `done` by one or more cycles, and the gap measurement catches that on the next access. A wrong capture condition appears as a bad `rdata` word in the `done` cycle of that same read, or, for a write, as a word that should have stayed unchanged.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1
    } seq_state_e;

    // strobe lane numbering, also the bit order of the half-cycle retime vector
    localparam int SB_CS  = 0;
    localparam int SB_ADV = 1;
    localparam int SB_WE  = 2;
    localparam int SB_OE  = 3;
    localparam int NUM_SB = 4;

endpackage

// File: rtl/strobe_seq_win.sv
module strobe_seq_win #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [CNT_W:0]   tick,
    input  logic [CNT_W-1:0] on_t,
    input  logic [CNT_W-1:0] off_t,
    input  logic             dbl,
    input  logic             half,
    output logic             strobe_n
);
    localparam int SW = CNT_W + 1;

    logic [SW-1:0] on_s;
    logic [SW-1:0] off_s;
    logic          win;
    logic          win_neg;

    assign on_s  = dbl ? {on_t, 1'b0}  : {1'b0, on_t};
    assign off_s = dbl ? {off_t, 1'b0} : {1'b0, off_t};
    assign win   = busy && (tick >= on_s) && (tick < off_s);

    // falling-edge copy gives the half-period later version
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) win_neg <= 1'b0;
        else        win_neg <= win;
    end

    assign strobe_n = half ? ~win_neg : ~win;
endmodule

// File: rtl/strobe_seq_ctl.sv
module strobe_seq_ctl
    import strobe_seq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int CS_W   = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  rd_len,
    input  logic [CNT_W-1:0]  wr_len,
    input  logic [CNT_W-1:0]  acc_time,
    input  logic [CNT_W-1:0]  turn_len,
    input  logic [CNT_W-1:0]  gap_len,
    input  logic              gap_same_en,
    input  logic              gap_diff_en,
    input  logic              tm_x2,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic [CNT_W:0]    tick,
    output logic              cur_write,
    output logic [CS_W-1:0]   cur_cs,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int SW = CNT_W + 1;
    localparam int IW = CNT_W + 2;

    function automatic logic [SW-1:0] scl(input logic [CNT_W-1:0] v, input logic d);
        return d ? {v, 1'b0} : {1'b0, v};
    endfunction

    seq_state_e    state_q, state_d;
    logic [SW-1:0] tick_q;
    logic [IW-1:0] idle_q;
    logic [SW-1:0] len_s, last_s, acc_s, cap_s;
    logic          gap_on;
    logic [IW-1:0] need;
    logic          accept, finish;

    assign len_s  = scl(cur_write ? wr_len : rd_len, tm_x2);
    assign last_s = (len_s == '0) ? '0 : len_s - 1'b1;
    assign acc_s  = scl(acc_time, tm_x2);
    assign cap_s  = (acc_s > last_s) ? last_s : acc_s;

    assign gap_on = (req_cs == cur_cs) ? gap_same_en : gap_diff_en;
    assign need   = {1'b0, scl(turn_len, tm_x2)} + (gap_on ? {1'b0, scl(gap_len, tm_x2)} : '0);

    assign req_ready = (state_q == ST_IDLE) && (idle_q >= need);
    assign accept    = req_valid && req_ready;
    assign finish    = (state_q == ST_ACCESS) && (tick_q == last_s);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ACCESS;
            ST_ACCESS: if (finish) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q    <= '0;
            idle_q    <= '1;
            cur_write <= 1'b0;
            cur_cs    <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            done      <= 1'b0;
            rdata     <= '0;
        end else begin
            done <= finish;
            if (accept) begin
                tick_q    <= '0;
                cur_write <= req_write;
                cur_cs    <= req_cs;
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
            end else if (state_q == ST_ACCESS) begin
                tick_q <= tick_q + 1'b1;
            end
            if (finish)                                   idle_q <= '0;
            else if (state_q == ST_IDLE && idle_q != '1)  idle_q <= idle_q + 1'b1;
            if (state_q == ST_ACCESS && !cur_write && tick_q == cap_s)
                rdata <= mem_rdata;
        end
    end

    assign busy = (state_q == ST_ACCESS);
    assign tick = tick_q;
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import strobe_seq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cs_on,
    input  logic [CNT_W-1:0]  cs_off_rd,
    input  logic [CNT_W-1:0]  cs_off_wr,
    input  logic [CNT_W-1:0]  adv_on,
    input  logic [CNT_W-1:0]  adv_off_rd,
    input  logic [CNT_W-1:0]  adv_off_wr,
    input  logic [CNT_W-1:0]  we_on,
    input  logic [CNT_W-1:0]  we_off,
    input  logic [CNT_W-1:0]  oe_on,
    input  logic [CNT_W-1:0]  oe_off,
    input  logic [CNT_W-1:0]  acc_time,
    input  logic [CNT_W-1:0]  rd_len,
    input  logic [CNT_W-1:0]  wr_len,
    input  logic [CNT_W-1:0]  turn_len,
    input  logic [CNT_W-1:0]  gap_len,
    input  logic              gap_same_en,
    input  logic              gap_diff_en,
    input  logic [3:0]        half_dly,
    input  logic              tm_x2,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_adv_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              busy;
    logic [CNT_W:0]    tick;
    logic              cur_write;
    logic [CS_W-1:0]   cur_cs;
    logic [CNT_W-1:0]  on_a  [NUM_SB];
    logic [CNT_W-1:0]  off_a [NUM_SB];
    logic [NUM_SB-1:0] sb_n;

    strobe_seq_ctl #(
        .CNT_W(CNT_W), .CS_W(CS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_len(rd_len), .wr_len(wr_len), .acc_time(acc_time),
        .turn_len(turn_len), .gap_len(gap_len),
        .gap_same_en(gap_same_en), .gap_diff_en(gap_diff_en), .tm_x2(tm_x2),
        .mem_rdata(mem_rdata),
        .busy(busy), .tick(tick), .cur_write(cur_write), .cur_cs(cur_cs),
        .cur_addr(mem_addr), .cur_wdata(mem_wdata), .done(done), .rdata(rdata)
    );

    assign on_a[SB_CS]   = cs_on;
    assign off_a[SB_CS]  = cur_write ? cs_off_wr : cs_off_rd;
    assign on_a[SB_ADV]  = adv_on;
    assign off_a[SB_ADV] = cur_write ? adv_off_wr : adv_off_rd;
    assign on_a[SB_WE]   = we_on;
    assign off_a[SB_WE]  = we_off;
    assign on_a[SB_OE]   = oe_on;
    assign off_a[SB_OE]  = oe_off;

    for (genvar g = 0; g < NUM_SB; g++) begin : g_sb
        strobe_seq_win #(.CNT_W(CNT_W)) u_win (
            .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick),
            .on_t(on_a[g]), .off_t(off_a[g]), .dbl(tm_x2),
            .half(half_dly[g]), .strobe_n(sb_n[g])
        );
    end

    for (genvar c = 0; c < NCS; c++) begin : g_cs
        assign mem_cs_n[c] = (cur_cs == CS_W'(c)) ? sb_n[SB_CS] : 1'b1;
    end

    assign mem_adv_n = sb_n[SB_ADV];
    assign mem_we_n  = sb_n[SB_WE];
    assign mem_oe_n  = sb_n[SB_OE];
endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk #(
    parameter int NCS    = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [NCS-1:0]    mem_cs_n,
    input logic              mem_adv_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_valid && req_ready)) |-> $stable(mem_addr));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> (&mem_cs_n && mem_adv_n && mem_we_n && mem_oe_n));
endmodule

bind strobe_seq strobe_seq_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr)
);

// File: tb/strobe_seq_test.sv
module strobe_seq_test;
    localparam int NCS = 4, CNT_W = 5, ADDR_W = 16, DATA_W = 16, CS_W = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, req_valid, req_ready, req_write, done;
    logic [CS_W-1:0] req_cs;
    logic [ADDR_W-1:0] req_addr, mem_addr;
    logic [DATA_W-1:0] req_wdata, rdata, mem_wdata, mem_rdata;
    logic [CNT_W-1:0] cs_on, cs_off_rd, cs_off_wr, adv_on, adv_off_rd, adv_off_wr;
    logic [CNT_W-1:0] we_on, we_off, oe_on, oe_off, acc_time, rd_len, wr_len, turn_len, gap_len;
    logic gap_same_en, gap_diff_en, tm_x2, mem_adv_n, mem_we_n, mem_oe_n;
    logic [3:0] half_dly;
    logic [NCS-1:0] mem_cs_n;

    strobe_seq #(.NCS(NCS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .cs_on(cs_on), .cs_off_rd(cs_off_rd), .cs_off_wr(cs_off_wr),
        .adv_on(adv_on), .adv_off_rd(adv_off_rd), .adv_off_wr(adv_off_wr),
        .we_on(we_on), .we_off(we_off), .oe_on(oe_on), .oe_off(oe_off),
        .acc_time(acc_time), .rd_len(rd_len), .wr_len(wr_len), .turn_len(turn_len),
        .gap_len(gap_len), .gap_same_en(gap_same_en), .gap_diff_en(gap_diff_en),
        .half_dly(half_dly), .tm_x2(tm_x2), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int  n_chk = 0, n_bad = 0;
    bit  first = 1'b1;
    int  prev_cs = 0;
    logic [DATA_W-1:0] exp_rd = '0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int scl(input int v, input bit d);
        return d ? 2 * v : v;
    endfunction

    function automatic bit win(input int t, input int on, input int off, input int len);
        return (t >= 0) && (t < len) && (t >= on) && (t < off);
    endfunction

    // expected active-low level in half h of cycle t
    function automatic bit lvl(input int t, input int h, input bit hb, input int on, input int off, input int len);
        return (hb && h == 0) ? !win(t - 1, on, off, len) : !win(t, on, off, len);
    endfunction

    task automatic zero_timing();
        {cs_on, cs_off_rd, cs_off_wr, adv_on, adv_off_rd, adv_off_wr} = '0;
        {we_on, we_off, oe_on, oe_off, acc_time, rd_len, wr_len, turn_len, gap_len} = '0;
        {gap_same_en, gap_diff_en, tm_x2} = '0;
        half_dly = 4'h0;
    endtask

    // Called at +15 ns of a done cycle (or idle cycle); returns at +15 ns of the next done cycle.
    task automatic access(input bit wr, input int cs, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] salt);
        int need, n, len, cap, cs_off, adv_off;
        bit gapon;
        logic [NCS-1:0] e_cs;
        string tx;
        req_write = wr; req_cs = CS_W'(cs); req_addr = a; req_wdata = wd; req_valid = 1'b1;
        gapon = (cs == prev_cs) ? gap_same_en : gap_diff_en;
        need  = scl(turn_len, tm_x2) + (gapon ? scl(gap_len, tm_x2) : 0);
        if (first) need = 0;
        n = 0;
        forever begin
            #1;
            if (req_ready || n > 400) break;
            @(posedge clk); #15;
            n++;
        end
        check(n == need, (gapon && !first) ? "R10 gap before ready" : "R9 turnaround before ready", n, need);
        len = scl(wr ? wr_len : rd_len, tm_x2);
        if (len < 1) len = 1;
        cap = scl(acc_time, tm_x2);
        if (cap > len - 1) cap = len - 1;
        cs_off  = scl(wr ? cs_off_wr : cs_off_rd, tm_x2);
        adv_off = scl(wr ? adv_off_wr : adv_off_rd, tm_x2);
        tx = $sformatf("%s%s", (half_dly != 0) ? " R5" : "", tm_x2 ? " R6" : "");
        @(posedge clk);
        for (int t = 0; t <= len; t++) begin
            if (t > 0) @(posedge clk);
            #1;
            if (t == 0) req_valid = 1'b0;
            mem_rdata = salt ^ DATA_W'(t);
            for (int h = 0; h < 2; h++) begin
                if (h == 0) #4; else #10;
                e_cs = '1;
                e_cs[cs] = lvl(t, h, half_dly[0], scl(cs_on, tm_x2), cs_off, len);
                check(mem_cs_n == e_cs, {"R2 chip-select", tx}, mem_cs_n, e_cs);
                check(mem_adv_n == lvl(t, h, half_dly[1], scl(adv_on, tm_x2), adv_off, len),
                      {"R3 address valid", tx}, mem_adv_n, lvl(t, h, half_dly[1], scl(adv_on, tm_x2), adv_off, len));
                check(mem_we_n == lvl(t, h, half_dly[2], scl(we_on, tm_x2), scl(we_off, tm_x2), len),
                      {"R4 write strobe", tx}, mem_we_n, lvl(t, h, half_dly[2], scl(we_on, tm_x2), scl(we_off, tm_x2), len));
                check(mem_oe_n == lvl(t, h, half_dly[3], scl(oe_on, tm_x2), scl(oe_off, tm_x2), len),
                      {"R4 output enable", tx}, mem_oe_n, lvl(t, h, half_dly[3], scl(oe_on, tm_x2), scl(oe_off, tm_x2), len));
                check(done == (t == len), "R7 done timing", done, (t == len));
                if (t < len) check(!req_ready, "R12 ready during access", req_ready, 0);
            end
            if (t == 0 || t == len) begin
                check(mem_addr == a, "R11 address held", mem_addr, a);
                check(mem_wdata == wd, "R11 write data held", mem_wdata, wd);
            end
        end
        if (!wr) exp_rd = salt ^ DATA_W'(cap);
        check(rdata == exp_rd, wr ? "R8 rdata kept on write" : "R8 read capture", rdata, exp_rd);
        prev_cs = cs;
        first = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R12 actual=hung expected=complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cs = '0;
        req_addr = '0; req_wdata = '0; mem_rdata = '0;
        zero_timing();
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        @(posedge clk); #15;
        // R1 reset state
        check(&mem_cs_n && mem_adv_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_cs_n, mem_adv_n, mem_we_n, mem_oe_n}, 7'h7f);
        check(!done, "R1 done low", done, 0);
        check(req_ready, "R1 ready high", req_ready, 1);
        check(rdata == '0, "R1 rdata zero", rdata, 0);

        // R7 all-zero timing: one-cycle access, nothing asserted
        access(1'b0, 0, 16'h1111, 16'h0, 16'hA5A0);
        // plain read windows
        cs_on = 2; cs_off_rd = 5; cs_off_wr = 9; adv_on = 0; adv_off_rd = 2; adv_off_wr = 3;
        oe_on = 3; oe_off = 7; we_on = 1; we_off = 1; rd_len = 8; wr_len = 10; acc_time = 4;
        access(1'b0, 1, 16'h2222, 16'h0, 16'h3C00);
        // R5 every strobe half a cycle later
        half_dly = 4'hF;
        access(1'b0, 1, 16'h2223, 16'h0, 16'h4D00);
        // R6 doubled write, OE window past the end
        half_dly = 4'h0; tm_x2 = 1'b1; we_on = 2; we_off = 4; oe_off = 31;
        access(1'b1, 1, 16'h3333, 16'hBEEF, 16'h0);
        // R10 same-device gap
        tm_x2 = 1'b0; turn_len = 2; gap_len = 3; gap_same_en = 1'b1;
        access(1'b0, 1, 16'h4444, 16'h0, 16'h5E00);
        // R9 different device, gap not applied
        access(1'b0, 2, 16'h5555, 16'h0, 16'h6F00);
        // R10 different device gap
        gap_diff_en = 1'b1; gap_same_en = 1'b0;
        access(1'b1, 3, 16'h6666, 16'hCAFE, 16'h0);
        // R8 data-valid time beyond the length is clamped
        acc_time = 20; rd_len = 6;
        access(1'b0, 3, 16'h7777, 16'h0, 16'h7100);
        // R8 write keeps previous read word
        access(1'b1, 0, 16'h8888, 16'h1234, 16'h0);

        for (int i = 0; i < 200; i++) begin
            cs_on = CNT_W'($urandom_range(0, 31)); cs_off_rd = CNT_W'($urandom_range(0, 31));
            cs_off_wr = CNT_W'($urandom_range(0, 31)); adv_on = CNT_W'($urandom_range(0, 31));
            adv_off_rd = CNT_W'($urandom_range(0, 31)); adv_off_wr = CNT_W'($urandom_range(0, 31));
            we_on = CNT_W'($urandom_range(0, 31)); we_off = CNT_W'($urandom_range(0, 31));
            oe_on = CNT_W'($urandom_range(0, 31)); oe_off = CNT_W'($urandom_range(0, 31));
            acc_time = CNT_W'($urandom_range(0, 31)); rd_len = CNT_W'($urandom_range(0, 31));
            wr_len = CNT_W'($urandom_range(0, 31)); turn_len = CNT_W'($urandom_range(0, 7));
            gap_len = CNT_W'($urandom_range(0, 15)); gap_same_en = 1'($urandom);
            gap_diff_en = 1'($urandom); tm_x2 = 1'($urandom); half_dly = 4'($urandom);
            access(1'($urandom), int'($urandom_range(0, NCS - 1)), 16'($urandom), 16'($urandom), 16'($urandom));
        end
        finish_run();
    end
endmodule